// File: doc/BRIEF.md
# Three-Lane 7:1 Parallel Serializer

This block turns a 21-bit parallel word into three serial lanes. It takes one word per pixel-clock period and sends seven bits on each lane per period. A fourth output, the forwarded clock, carries a fixed seven-slot waveform. A receiver uses this waveform to find the word boundaries and rebuild the word.

The block has two inputs that drive its timing: a pixel clock and a bit clock at seven times that rate. The two clocks are phase-aligned. A phase strobe marks the bit-clock edge that starts each frame, and that edge coincides with the rising edge of the pixel clock. The word is captured on the falling edge of the pixel clock and held. The shift registers load the held word at the next frame start, so a new capture never disturbs a frame that is still being sent.

An active-low shutdown input clears every register without waiting for a clock edge. While it is low, all lanes and the forwarded clock are held low. After it is released, the outputs stay low until the first word captured after the release has been loaded.

Top module: `tri_lane_serializer`

## Requirements
- R1: `pix_data` is sampled on the falling edge of `pix_clk`. A change to `pix_data` later in the same pixel period does not alter the word that is sent.
- R2: Lane 0 carries word bits 6:0, lane 1 carries bits 13:7 and lane 2 carries bits 20:14.
- R3: Each lane sends its slice least significant bit first. Bit 0 is present during the bit-clock cycle that follows the frame-start edge, and the following bits come on successive bit-clock cycles.
- R4: During a frame that carries a word, `fwd_clk_out` takes the values 1,1,0,0,0,1,1 on bit slots 0 through 6.
- R5: A word captured in pixel period n is sent in full during frame n+1. Back-to-back words are sent with no gap or repeat, one word per frame.
- R6: While `shdn_n` is low, `lane_out` and `fwd_clk_out` are 0, and this takes effect at once, not at a clock edge.
- R7: After `shdn_n` rises, all outputs stay 0 until the frame that follows the first falling `pix_clk` edge seen with `shdn_n` high. That frame carries the word from that edge, and no word from before the shutdown ever appears.

Frame-start strobe: `frame_start` is high at every seventh bit-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the word is captured on its falling edge |
| bit_clk | input | 1 | Bit clock at seven times the pixel rate, phase-aligned to pix_clk |
| frame_start | input | 1 | High at the bit-clock edge that begins each 7-bit frame |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| pix_data | input | 21 | Parallel word to be sent |
| lane_out | output | 3 | Serial data lanes; bit i is lane i |
| fwd_clk_out | output | 1 | Forwarded clock carrying the 1100011 frame waveform |

## Verification
The bench builds the block with its default parameters: three lanes of seven bits, LSB-first order and the 1100011 frame waveform.

With that configuration, a walking one can visit each of the 21 bit positions. This exposes any misrouted lane or reversed bit order. The all-ones and all-zeros words and a long run of back-to-back scrambled words check data integrity.

Each word is overwritten with its complement after the falling edge, which proves that only the value at that edge is sent. The bench recovers each word from the lanes by aligning on the forwarded-clock waveform. Shutdowns are applied both before and after the capture point of a frame, and the bench checks that the outputs stay quiet until the right frame after release.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
   // Frame waveform on the forwarded clock, read left to right as slot 0..6.
   localparam logic [6:0] FWD_PAT_7 = 7'b1100011;

   function automatic int unsigned slot_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/ser7_capture.sv
module ser7_capture #(
   parameter int unsigned W = 21
) (
   input  logic         pix_clk,
   input  logic         shdn_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] word_o,
   output logic         valid_o
);
   initial assert (W >= 1) else $error("ser7_capture: W must be at least 1");

   // Falling-edge capture into the holding register (R1).
   always_ff @(negedge pix_clk or negedge shdn_n) begin
      if (!shdn_n) begin
         word_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         word_o  <= d_i;
         valid_o <= 1'b1;
      end
   end
endmodule

// File: rtl/ser7_framer.sv
module ser7_framer #(
   parameter int unsigned     BITS    = 7,
   parameter logic [BITS-1:0] FWD_PAT = ser7_pkg::FWD_PAT_7
) (
   input  logic bit_clk,
   input  logic shdn_n,
   input  logic frame_start_i,
   input  logic hold_valid_i,
   output logic run_o,
   output logic fwd_o
);
   localparam int unsigned   SW   = ser7_pkg::slot_width(BITS);
   localparam logic [SW-1:0] LAST = SW'(BITS - 1);

   initial assert (BITS >= 2) else $error("ser7_framer: BITS must be at least 2");

   logic [SW-1:0]   slot;
   logic            seen;
   logic [BITS-1:0] pat_after;

   always_comb pat_after = FWD_PAT << (slot + 1'b1);

   always_ff @(posedge bit_clk or negedge shdn_n) begin
      if (!shdn_n) begin
         slot  <= '0;
         seen  <= 1'b0;
         run_o <= 1'b0;
         fwd_o <= 1'b0;
      end else if (frame_start_i) begin
         slot  <= '0;
         seen  <= 1'b1;
         run_o <= hold_valid_i;
         fwd_o <= hold_valid_i & FWD_PAT[BITS-1];
      end else if (slot != LAST) begin
         slot  <= slot + 1'b1;
         fwd_o <= run_o & pat_after[BITS-1];
      end else begin
         fwd_o <= 1'b0;
      end
   end

   // R4: a loaded frame opens with the first waveform slot
   a_r4_fwd_first_slot: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      (frame_start_i && hold_valid_i) |=> (fwd_o == FWD_PAT[BITS-1]));

   // R5: frame strobes arrive exactly one frame apart
   a_r5_strobe_spacing: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      (frame_start_i && seen) |-> (slot == LAST));
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
   parameter int unsigned BITS      = 7,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic            bit_clk,
   input  logic            shdn_n,
   input  logic            load_i,
   input  logic            valid_i,
   input  logic [BITS-1:0] slice_i,
   output logic            ser_o
);
   initial assert (BITS >= 2) else $error("ser7_lane: BITS must be at least 2");

   logic [BITS-1:0] shreg;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge bit_clk or negedge shdn_n) begin
            if (!shdn_n)     shreg <= '0;
            else if (load_i) shreg <= valid_i ? slice_i : '0;
            else             shreg <= {1'b0, shreg[BITS-1:1]};
         end
         assign ser_o = shreg[0];
      end else begin : g_msb
         always_ff @(posedge bit_clk or negedge shdn_n) begin
            if (!shdn_n)     shreg <= '0;
            else if (load_i) shreg <= valid_i ? slice_i : '0;
            else             shreg <= {shreg[BITS-2:0], 1'b0};
         end
         assign ser_o = shreg[BITS-1];
      end
   endgenerate

   // R3: the first bit of the slice leads the frame
   a_r3_first_bit: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      (load_i && valid_i) |=> (ser_o == $past(LSB_FIRST ? slice_i[0] : slice_i[BITS-1])));
endmodule

// File: rtl/tri_lane_serializer.sv
module tri_lane_serializer #(
   parameter int unsigned     LANES     = 3,
   parameter int unsigned     BITS      = 7,
   parameter bit              LSB_FIRST = 1'b1,
   parameter logic [BITS-1:0] FWD_PAT   = ser7_pkg::FWD_PAT_7
) (
   input  logic                  pix_clk,
   input  logic                  bit_clk,
   input  logic                  frame_start,
   input  logic                  shdn_n,
   input  logic [LANES*BITS-1:0] pix_data,
   output logic [LANES-1:0]      lane_out,
   output logic                  fwd_clk_out
);
   localparam int unsigned W = LANES * BITS;

   initial assert (LANES >= 1) else $error("tri_lane_serializer: LANES must be at least 1");

   logic [W-1:0] hold_word;
   logic         hold_valid;
   logic         run;

   ser7_capture #(.W(W)) u_cap (
      .pix_clk (pix_clk),
      .shdn_n  (shdn_n),
      .d_i     (pix_data),
      .word_o  (hold_word),
      .valid_o (hold_valid)
   );

   ser7_framer #(.BITS(BITS), .FWD_PAT(FWD_PAT)) u_frm (
      .bit_clk       (bit_clk),
      .shdn_n        (shdn_n),
      .frame_start_i (frame_start),
      .hold_valid_i  (hold_valid),
      .run_o         (run),
      .fwd_o         (fwd_clk_out)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      ser7_lane #(.BITS(BITS), .LSB_FIRST(LSB_FIRST)) u_lane (
         .bit_clk (bit_clk),
         .shdn_n  (shdn_n),
         .load_i  (frame_start),
         .valid_i (hold_valid),
         .slice_i (hold_word[l*BITS +: BITS]),
         .ser_o   (lane_out[l])
      );
   end

   // R6: shutdown holds every output low
   a_r6_idle_in_shutdown: assert property (@(negedge bit_clk)
      !shdn_n |-> (lane_out == '0 && !fwd_clk_out));

   // R7: nothing leaves the block before a valid word is loaded
   a_r7_quiet_until_load: assert property (@(posedge bit_clk) disable iff (!shdn_n)
      !run |-> (lane_out == '0 && !fwd_clk_out));
endmodule

// File: tb/tri_lane_serializer_test.sv
module tri_lane_serializer_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int NF         = 260;

   logic        pclk = 1'b0, bclk = 1'b0, fs = 1'b0, shdn_n = 1'b0;
   logic [20:0] din = '0;
   logic [2:0]  lanes;
   logic        fclk;

   int   checks = 0, errors = 0;
   bit   done = 1'b0, quiet = 1'b1, pending = 1'b0;
   int   ns = 0, nr = 0;
   logic [20:0] sent [0:511];
   logic [6:0]  hist_f = '0;
   logic [6:0]  hist_l [3];

   tri_lane_serializer uut (
      .pix_clk     (pclk),
      .bit_clk     (bclk),
      .frame_start (fs),
      .shdn_n      (shdn_n),
      .pix_data    (din),
      .lane_out    (lanes),
      .fwd_clk_out (fclk)
   );

   function automatic logic [20:0] word_of(input int f);
      logic [31:0] t;
      if (f < 21)  return 21'(1) << f;
      if (f == 21) return '1;
      if (f == 22) return '0;
      t = (32'(f) * 32'h9E3779B1) ^ (32'(f) << 11) ^ 32'h0005A5A5;
      return t[20:0];
   endfunction

   task automatic go_down();
      shdn_n = 1'b0; quiet = 1'b1; pending = 1'b0; ns = 0; nr = 0;
      hist_f = '0;
      for (int l = 0; l < 3; l++) hist_l[l] = '0;
   endtask

   task automatic events(input int f, input int k, input int ph);
      if (f == 2   && k == 1 && ph == 1) shdn_n = 1'b1;
      if (f == 150 && k == 2 && ph == 1) go_down();
      if (f == 153 && k == 5 && ph == 1) shdn_n = 1'b1;
      if (f == 200 && k == 4 && ph == 0) go_down();
      if (f == 202 && k == 1 && ph == 0) shdn_n = 1'b1;
   endtask

   task automatic sample(input int k);
      logic [20:0] rec;
      hist_f = {hist_f[5:0], fclk};
      for (int l = 0; l < 3; l++) hist_l[l] = {hist_l[l][5:0], lanes[l]};
      if (quiet) begin
         checks++;
         if (lanes !== 3'b000 || fclk !== 1'b0) begin
            errors++;
            $display("FAIL %s outputs not idle: lanes=%b fwd=%b expected 000/0",
                     shdn_n ? "R7" : "R6", lanes, fclk);
         end
      end else if (k == 6) begin
         checks++;
         if (hist_f !== 7'b1100011) begin
            errors++;
            $display("FAIL R4 forwarded clock frame=%b expected 1100011", hist_f);
         end else begin
            rec = '0;
            for (int l = 0; l < 3; l++)
               for (int j = 0; j < 7; j++) rec[7*l + j] = hist_l[l][6-j];
            checks++;
            if (nr >= ns) begin
               errors++;
               $display("FAIL R5 word %h recovered with none pending (sent %0d recv %0d)", rec, ns, nr);
            end else if (rec !== sent[nr]) begin
               errors++;
               $display("FAIL R1 R2 R3 recovered %h expected %h", rec, sent[nr]);
            end
            nr++;
         end
      end
   endtask

   initial begin
      for (int l = 0; l < 3; l++) hist_l[l] = '0;
      #(HALF);
      // Reset state
      checks++;
      if (lanes !== 3'b000 || fclk !== 1'b0) begin
         errors++;
         $display("FAIL R6 reset outputs lanes=%b fwd=%b expected 000/0", lanes, fclk);
      end
      #(HALF);
      for (int f = 0; f < NF; f++) begin
         for (int k = 0; k < 7; k++) begin
            bclk = 1'b1;
            if (k == 0) begin
               pclk = 1'b1;
               if (pending) quiet = 1'b0;
            end
            #2;
            if (k == 0) din = word_of(f);
            events(f, k, 0);
            #(HALF - 2);
            bclk = 1'b0;
            if (k == 3) pclk = 1'b0;
            sample(k);
            if (k == 3 && shdn_n) begin
               sent[ns] = din; ns++; pending = 1'b1;
            end
            if (k == 4) din = ~din;   // junk after capture point (R1)
            fs = (k == 6);
            #2;
            events(f, k, 1);
            #(HALF - 2);
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL R5 watchdog expired: actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule